// File: doc/BRIEF.md
# Clock-Stop Request Sequencer

This block sits beside a processor core's execution control and answers an external request to stop or retune the core clock. The request pin is active low and can change at any time with respect to the core clock. The block synchronises it and then waits for the next instruction boundary. At that boundary it halts execution and orders the core to empty its pipelines and write buffers. Once both report empty, it asks the bus unit to run a dedicated stop-grant bus cycle. When that cycle completes, the block reports that the core is stopped. It stays stopped until the request pin is released, and then returns the core to normal execution.

A pending interrupt of higher priority wins over the stop request at any boundary. The block keeps waiting and halts at the first boundary where no such interrupt is pending. The request must stay asserted until the grant cycle has finished. If it is withdrawn before execution has halted, the block simply goes back to running. The grant cycle is a request/acknowledge pair: `grant_req` stays high, unchanged, until the bus unit pulses `grant_ack`. The bus unit may stall for as many cycles as it needs, and the block drops `grant_req` on the edge that samples the acknowledge. All other pins are plain levels.

Top module: `clkstop_seq`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `halt_exec`, `drain_cmd`, `grant_req` and `stopped` are all 0, and the block is in its running phase.
- R2: The request pin passes through SYNC_STAGES (default 2) flops before it is used. With `insn_bound` held at 1 and `hi_irq_pend` held at 0, `halt_exec` rises on the (SYNC_STAGES+2)-th rising clock edge after `stop_req_n` falls, and not earlier.
- R3: Once the request is recognised, execution halts only on an edge where `insn_bound` is 1. While `insn_bound` stays 0, `halt_exec` stays 0.
- R4: On an edge where `insn_bound` is 1 and `hi_irq_pend` is 1, the block does not halt. It halts on the first later edge that sees `insn_bound` 1 with `hi_irq_pend` 0.
- R5: After halting, `drain_cmd` is 1 until an edge samples both `pipe_empty` and `wbuf_empty` at 1. `grant_req` only rises on the edge after such a sample.
- R6: `grant_req` stays 1 until an edge samples `grant_ack` at 1. After that edge `grant_req` is 0 and `stopped` is 1.
- R7: `stopped` and `halt_exec` stay 1 while the request is held. When `stop_req_n` rises, both fall on the (SYNC_STAGES+1)-th rising edge after it.
- R8: If the request is withdrawn before the halting boundary, the block returns to running. Later boundaries then do not halt it.
- R9: At most one of `drain_cmd`, `grant_req` and `stopped` is 1 in any cycle, and each of them implies `halt_exec` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stop_req_n | input | 1 | Stop/retune clock request, active low, asynchronous |
| insn_bound | input | 1 | High in a cycle that ends an instruction |
| hi_irq_pend | input | 1 | A higher-priority interrupt is pending |
| pipe_empty | input | 1 | Internal pipelines are empty |
| wbuf_empty | input | 1 | Write buffers are empty |
| grant_ack | input | 1 | Bus unit has completed the stop-grant cycle |
| halt_exec | output | 1 | Stop issuing instructions |
| drain_cmd | output | 1 | Empty pipelines and write buffers |
| grant_req | output | 1 | Run a stop-grant bus cycle |
| stopped | output | 1 | Grant cycle done; the clock may be stopped |

## Verification
Some properties hold from one cycle to the next, and the assertions check those on every cycle. These are the mutual exclusion of the phase outputs and the rule that each of them implies a halt. They also check that a halt begins only after a boundary sampled with no higher-priority interrupt, and that a grant follows a drain that saw both buffers empty. The grant request must be held until its acknowledge, and the stopped phase must follow that acknowledge. The exact latency through the synchroniser, on the way in and on the way out, can only be shown by the bench scenarios, which count edges from a pin change. The same holds for withdrawal of the request before a boundary, and for sequences where interrupts keep masking several boundaries in a row.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  typedef enum logic [2:0] {
    PH_RUN   = 3'd0,
    PH_WAIT  = 3'd1,
    PH_DRAIN = 3'd2,
    PH_GRANT = 3'd3,
    PH_STOP  = 3'd4
  } clkstop_ph_e;
endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= RESET_VAL;
          else        chain_q[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= RESET_VAL;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/clkstop_fsm.sv
module clkstop_fsm
  import clkstop_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_act,
  input  logic        insn_bound,
  input  logic        hi_irq_pend,
  input  logic        all_empty,
  input  logic        grant_ack,
  output clkstop_ph_e phase
);
  clkstop_ph_e ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_RUN:   if (req_act) ph_d = PH_WAIT;
      PH_WAIT: begin
        if (!req_act)                       ph_d = PH_RUN;
        else if (insn_bound && !hi_irq_pend) ph_d = PH_DRAIN;
      end
      PH_DRAIN: if (all_empty) ph_d = PH_GRANT;
      PH_GRANT: if (grant_ack) ph_d = PH_STOP;
      PH_STOP:  if (!req_act)  ph_d = PH_RUN;
      default:  ph_d = PH_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_RUN;
    else        ph_q <= ph_d;
  end

  assign phase = ph_q;
endmodule

// File: rtl/clkstop_seq.sv
module clkstop_seq
  import clkstop_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req_n,
  input  logic insn_bound,
  input  logic hi_irq_pend,
  input  logic pipe_empty,
  input  logic wbuf_empty,
  input  logic grant_ack,
  output logic halt_exec,
  output logic drain_cmd,
  output logic grant_req,
  output logic stopped
);
  logic        req_act;
  clkstop_ph_e phase;

  clkstop_sync #(
    .STAGES    (SYNC_STAGES),
    .RESET_VAL (1'b0)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (~stop_req_n),
    .q_sync  (req_act)
  );

  clkstop_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_act     (req_act),
    .insn_bound  (insn_bound),
    .hi_irq_pend (hi_irq_pend),
    .all_empty   (pipe_empty & wbuf_empty),
    .grant_ack   (grant_ack),
    .phase       (phase)
  );

  always_comb begin
    drain_cmd = (phase == PH_DRAIN);
    grant_req = (phase == PH_GRANT);
    stopped   = (phase == PH_STOP);
    halt_exec = drain_cmd | grant_req | stopped;
  end
endmodule

// File: rtl/clkstop_chk.sv
module clkstop_chk (
  input logic clk,
  input logic rst_n,
  input logic insn_bound,
  input logic hi_irq_pend,
  input logic pipe_empty,
  input logic wbuf_empty,
  input logic grant_ack,
  input logic halt_exec,
  input logic drain_cmd,
  input logic grant_req,
  input logic stopped
);
  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({drain_cmd, grant_req, stopped})); // R9
  AST_PHASE_HALTS: assert property (@(posedge clk) disable iff (!rst_n) (drain_cmd || grant_req || stopped) |-> halt_exec); // R9
  AST_HALT_AT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) $rose(halt_exec) |-> ($past(insn_bound) && !$past(hi_irq_pend))); // R4
  AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (drain_cmd && !(pipe_empty && wbuf_empty)) |=> drain_cmd); // R5
  AST_GRANT_AFTER_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) $rose(grant_req) |-> $past(drain_cmd && pipe_empty && wbuf_empty)); // R5
  AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (grant_req && !grant_ack) |=> grant_req); // R6
  AST_STOP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n) (grant_req && grant_ack) |=> (stopped && !grant_req)); // R6
endmodule

bind clkstop_seq clkstop_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .insn_bound  (insn_bound),
  .hi_irq_pend (hi_irq_pend),
  .pipe_empty  (pipe_empty),
  .wbuf_empty  (wbuf_empty),
  .grant_ack   (grant_ack),
  .halt_exec   (halt_exec),
  .drain_cmd   (drain_cmd),
  .grant_req   (grant_req),
  .stopped     (stopped)
);

// File: tb/clkstop_seq_tb.sv
`timescale 1ns/1ps
module clkstop_seq_tb_top;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_req_n = 1'b1;
  logic insn_bound = 1'b0;
  logic hi_irq_pend = 1'b0;
  logic pipe_empty = 1'b0;
  logic wbuf_empty = 1'b0;
  logic grant_ack = 1'b0;
  logic halt_exec, drain_cmd, grant_req, stopped;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model: synchroniser chain and phase 0 run,1 wait,2 drain,3 grant,4 stopped
  bit [SYNC-1:0] m_sync = '0;
  int m_ph = 0;

  always #5 clk = ~clk;

  clkstop_seq #(.SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rst_n(rst_n), .stop_req_n(stop_req_n),
    .insn_bound(insn_bound), .hi_irq_pend(hi_irq_pend),
    .pipe_empty(pipe_empty), .wbuf_empty(wbuf_empty), .grant_ack(grant_ack),
    .halt_exec(halt_exec), .drain_cmd(drain_cmd), .grant_req(grant_req), .stopped(stopped)
  );

  function automatic int next_ph(int ph, bit req, bit bnd, bit irq, bit empt, bit ack);
    case (ph)
      0: return req ? 1 : 0;
      1: return !req ? 0 : ((bnd && !irq) ? 2 : 1);
      2: return empt ? 3 : 2;
      3: return ack ? 4 : 3;
      default: return req ? 4 : 0;
    endcase
  endfunction

  function automatic bit [3:0] exp_out(int ph);
    // {halt, drain, grant, stopped}
    return {ph >= 2, ph == 2, ph == 3, ph == 4};
  endfunction

  function automatic string ph_tag(int ph);
    case (ph)
      0, 1: return "R3";
      2: return "R5";
      3: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // one clock: advance model on the edge, compare at the following falling edge
  task automatic tick();
    @(posedge clk);
    m_ph = next_ph(m_ph, m_sync[SYNC-1], insn_bound, hi_irq_pend,
                   pipe_empty && wbuf_empty, grant_ack);
    m_sync = {m_sync[SYNC-2:0], ~stop_req_n};
    @(negedge clk);
    chk(ph_tag(m_ph), {halt_exec, drain_cmd, grant_req, stopped}, exp_out(m_ph));
    chk("R9", (drain_cmd + grant_req + stopped) <= 1 &&
              (!(drain_cmd || grant_req || stopped) || halt_exec), 1);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int seed;
    seed = 32'h5EED_C10C;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk("R1", {halt_exec, drain_cmd, grant_req, stopped}, 4'b0);
    rst_n = 1'b1;
    ticks(2);
    chk("R1", {halt_exec, drain_cmd, grant_req, stopped}, 4'b0);

    // directed: full sequence with latency counts
    insn_bound = 1'b1;
    stop_req_n = 1'b0;
    ticks(SYNC + 1);
    chk("R2", halt_exec, 1'b0);
    tick();
    chk("R2", halt_exec, 1'b1);
    chk("R5", drain_cmd, 1'b1);
    insn_bound = 1'b0;
    ticks(3);
    chk("R5", grant_req, 1'b0);
    pipe_empty = 1'b1;
    ticks(2);
    chk("R5", {drain_cmd, grant_req}, 2'b10);
    wbuf_empty = 1'b1;
    tick();
    chk("R6", {drain_cmd, grant_req}, 2'b01);
    ticks(3);
    chk("R6", grant_req, 1'b1);
    grant_ack = 1'b1;
    tick();
    grant_ack = 1'b0;
    chk("R6", {grant_req, stopped}, 2'b01);
    ticks(5);
    chk("R7", {halt_exec, stopped}, 2'b11);
    stop_req_n = 1'b1;
    ticks(SYNC);
    chk("R7", stopped, 1'b1);
    tick();
    chk("R7", {halt_exec, stopped}, 2'b00);
    pipe_empty = 1'b0;
    wbuf_empty = 1'b0;

    // directed: no boundary, then masked by interrupt
    stop_req_n = 1'b0;
    ticks(10);
    chk("R3", halt_exec, 1'b0);
    insn_bound = 1'b1;
    hi_irq_pend = 1'b1;
    ticks(5);
    chk("R4", halt_exec, 1'b0);
    hi_irq_pend = 1'b0;
    tick();
    chk("R4", halt_exec, 1'b1);
    insn_bound = 1'b0;
    pipe_empty = 1'b1;
    wbuf_empty = 1'b1;
    ticks(2);
    grant_ack = 1'b1;
    tick();
    grant_ack = 1'b0;
    stop_req_n = 1'b1;
    ticks(SYNC + 2);
    chk("R7", halt_exec, 1'b0);
    pipe_empty = 1'b0;
    wbuf_empty = 1'b0;

    // directed: request withdrawn before boundary
    stop_req_n = 1'b0;
    ticks(5);
    stop_req_n = 1'b1;
    ticks(SYNC + 2);
    insn_bound = 1'b1;
    ticks(6);
    chk("R8", halt_exec, 1'b0);
    insn_bound = 1'b0;

    // constrained random: request only released outside drain and grant
    for (int n = 0; n < 4000; n++) begin
      insn_bound  = ($urandom % 4) == 0;
      hi_irq_pend = ($urandom % 3) == 0;
      pipe_empty  = ($urandom % 3) != 0;
      wbuf_empty  = ($urandom % 3) != 0;
      grant_ack   = (m_ph == 3) && (($urandom % 4) == 0);
      if (stop_req_n) begin
        if (($urandom % 20) == 0) stop_req_n = 1'b0;
      end else if (m_ph == 1 || m_ph == 4 || m_ph == 0) begin
        if (($urandom % 15) == 0) stop_req_n = 1'b1;
      end
      tick();
    end
    finish_run();
  end
endmodule